// File: doc/BRIEF.md
# Zero-Cross Gated Volume Register

This block holds the gain code of an amplifier gain stage and decides when a newly written code reaches the stage. In manual mode a freshly accepted code stays pending. It is applied when the signed audio stream changes sign, or when a selectable timeout runs out, whichever happens first. Deferring the change this way keeps gain steps from landing in the middle of a large sample, where they would be heard as a click.

The block also handles the power-enable bit. While power is off, writes are dropped. When power turns on, the applied gain returns to the 0 dB code and a write lockout window opens. The block also hands control to an external automatic level control (ALC) source and takes it back. While ALC is enabled, its code drives the output and manual writes are ignored. The manual code in effect when ALC starts is captured as the starting point for ALC. When ALC is released, the manual code comes back only after two zero-cross-or-timeout events.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset, gain_o is 0x18 (0 dB), alc_seed_o is 0x18 and busy_o is 0. The gain code is 6 bits at 0.5 dB per step, where 0x00 is -12.0 dB and 0x3F is +19.5 dB.
- R2: In manual mode, an accepted code appears on gain_o on the first valid sample whose sign bit (the MSB of the two's complement sample) differs from the previous valid sample's sign. Until then gain_o keeps the old code.
- R3: If no zero crossing occurs, a pending code is applied on the N-th valid sample after the write, where N = TMO_BASE << tmo_sel_i (128, 256, 512 or 1024 by default). The count restarts on every accepted write and on every application.
- R4: A write made while pwr_en_i is 0 is discarded. It never reaches gain_o and leaves busy_o at 0.
- R5: One cycle after pwr_en_i rises, gain_o is 0x18 and the stored manual code is 0x18, whatever was written before.
- R6: Writes are discarded in the rise cycle and for INH_CYC = CLK_HZ*16/10000 cycles after it (1.6 ms), and busy_o is 1 during that window.
- R7: While alc_en_i is 1, gain_o equals alc_code_i. In the cycle after alc_en_i rises, alc_seed_o holds the code that was applied when ALC was enabled.
- R8: Writes made while alc_en_i is 1 are ignored. The manual code restored after ALC is the last one accepted in manual mode.
- R9: After alc_en_i falls, gain_o holds the last ALC code through the first zero-cross-or-timeout event. It changes to the last accepted manual code at the second event.
- R10: busy_o is 1 while a code is pending in manual mode, or while the ALC hand-back has not finished.
- R11: Samples with smp_valid_i low count neither as zero crossings nor toward the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_en_i | input | 1 | Power-enable bit |
| alc_en_i | input | 1 | ALC enable bit |
| tmo_sel_i | input | 2 | Timeout select, period TMO_BASE << sel samples |
| wr_en_i | input | 1 | Gain code write strobe |
| wr_code_i | input | 6 | Written gain code |
| alc_code_i | input | 6 | Gain code from the external ALC |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Signed audio sample |
| gain_o | output | 6 | Gain code applied to the stage |
| alc_seed_o | output | 6 | Code captured when ALC was enabled |
| busy_o | output | 1 | Lockout window, pending change or hand-back in progress |

## Verification
The directed patterns are:
- A sign flip right after a write, which shows that zero crossings are detected.
- A run of same-sign samples with invalid opposite-sign samples between them, which separates timeout application from zero-cross application and shows that unstrobed samples do not count.
- Timeouts at two select values, which show that the count scales with the select.
- Writes made during power-off, during the lockout window and during ALC, which show that each kind is dropped.
- An ALC release followed by two events, which separates the first event (gain held) from the second (manual code restored).

A seeded random stream then mixes writes, select changes, power cycles and ALC toggles, and is compared every cycle against a reference model built from the requirements.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
  localparam int unsigned CODE_W = 6;
  typedef logic [CODE_W-1:0] gain_code_t;
  localparam gain_code_t CODE_0DB = 6'h18;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT2 = 2'd1,
    HB_WAIT1 = 2'd2
  } hb_state_e;

  function automatic int unsigned inhibit_cycles(input longint unsigned clk_hz);
    return int'((clk_hz * 64'd16) / 64'd10000);
  endfunction
endpackage

// File: rtl/zc_sign_detect.sv
module zc_sign_detect #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             zc_o
);
  logic prev_sign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_sign <= 1'b0;
    else if (valid_i) prev_sign <= smp_i[SMP_W-1];
  end

  assign zc_o = valid_i && (smp_i[SMP_W-1] != prev_sign);
endmodule

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int unsigned TMO_BASE = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  output logic       tmo_o
);
  localparam int unsigned MAX_PER = TMO_BASE * 8;
  localparam int unsigned CW = $clog2(MAX_PER) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] per;

  assign per   = CW'(TMO_BASE) << sel_i;
  assign tmo_o = valid_i && (cnt >= per - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt <= '0;
    else if (restart_i) cnt <= '0;
    else if (valid_i)   cnt <= tmo_o ? '0 : cnt + CW'(1);
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CW'(MAX_PER));
endmodule

// File: rtl/zc_pwr_window.sv
module zc_pwr_window #(
  parameter int unsigned INH_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_en_i,
  output logic rise_o,
  output logic active_o
);
  localparam int unsigned IW = $clog2(INH_CYC + 1);

  logic          pwr_prev;
  logic [IW-1:0] cnt;

  assign rise_o   = pwr_en_i && !pwr_prev;
  assign active_o = (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_prev <= 1'b0;
      cnt      <= '0;
    end else begin
      pwr_prev <= pwr_en_i;
      if (!pwr_en_i)     cnt <= '0;
      else if (rise_o)   cnt <= IW'(INH_CYC);
      else if (active_o) cnt <= cnt - IW'(1);
    end
  end

  assert_off_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> !active_o);
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
  import zc_gain_pkg::*;
#(
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned TMO_BASE = 128,
  parameter longint unsigned CLK_HZ = 125000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_en_i,
  input  logic             alc_en_i,
  input  logic [1:0]       tmo_sel_i,
  input  logic             wr_en_i,
  input  logic [5:0]       wr_code_i,
  input  logic [5:0]       alc_code_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [5:0]       gain_o,
  output logic [5:0]       alc_seed_o,
  output logic             busy_o
);
  localparam int unsigned INH_CYC = inhibit_cycles(CLK_HZ);

  gain_code_t cur, tgt, seed;
  hb_state_e  hb;
  logic       alc_prev;
  logic       zc, tmo, evt;
  logic       pwr_rise, win_active;
  logic       alc_rise, alc_fall;
  logic       pending, wr_accept, restart;

  zc_sign_detect #(.SMP_W(SMP_W)) u_zc (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .smp_i, .zc_o(zc)
  );

  zc_timeout #(.TMO_BASE(TMO_BASE)) u_tmo (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .sel_i(tmo_sel_i),
    .restart_i(restart), .tmo_o(tmo)
  );

  zc_pwr_window #(.INH_CYC(INH_CYC)) u_win (
    .clk_i, .rst_ni, .pwr_en_i, .rise_o(pwr_rise), .active_o(win_active)
  );

  assign evt       = zc || tmo;
  assign alc_rise  = alc_en_i && !alc_prev;
  assign alc_fall  = !alc_en_i && alc_prev;
  assign pending   = (tgt != cur);
  assign wr_accept = wr_en_i && pwr_en_i && !pwr_rise && !win_active && !alc_en_i;
  assign restart   = pwr_rise || wr_accept || alc_fall ||
                     (evt && !alc_en_i && ((hb != HB_IDLE) || pending));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur      <= CODE_0DB;
      tgt      <= CODE_0DB;
      seed     <= CODE_0DB;
      hb       <= HB_IDLE;
      alc_prev <= 1'b0;
    end else begin
      alc_prev <= alc_en_i;
      if (alc_rise) seed <= cur;
      if (pwr_rise) begin
        cur <= CODE_0DB;
        tgt <= CODE_0DB;
        hb  <= HB_IDLE;
      end else begin
        if (wr_accept) tgt <= wr_code_i;
        if (alc_en_i) begin
          cur <= alc_code_i;
          hb  <= HB_IDLE;
        end else if (alc_fall) begin
          hb <= HB_WAIT2;
        end else if (hb != HB_IDLE) begin
          if (evt) begin
            if (hb == HB_WAIT1) begin
              cur <= tgt;
              hb  <= HB_IDLE;
            end else begin
              hb <= HB_WAIT1;
            end
          end
        end else if (evt && pending) begin
          cur <= tgt;
        end
      end
    end
  end

  assign gain_o     = alc_en_i ? alc_code_i : cur;
  assign alc_seed_o = seed;
  assign busy_o     = win_active || (hb != HB_IDLE) || (!alc_en_i && pending);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alc_en_i && !alc_fall && (hb == HB_IDLE) && !evt && !pwr_rise) |=> $stable(cur));

  assert_off_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> $stable(tgt));

  assert_pwr_default_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_rise |=> (gain_o == CODE_0DB || alc_en_i) && (tgt == CODE_0DB));

  assert_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_active |=> $stable(tgt));

  assert_seed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alc_rise |=> (alc_seed_o == $past(cur)));

  assert_alc_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alc_en_i && !pwr_rise) |=> $stable(tgt));

  assert_hb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hb != HB_IDLE) && !evt && !alc_en_i && !pwr_rise) |=> $stable(cur));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !alc_en_i && !pwr_rise) |=> $stable(cur));
endmodule

// File: tb/sim_zc_gain_ctrl.sv
module sim_zc_gain_ctrl;
  localparam int unsigned SMP_W    = 16;
  localparam int unsigned TMO_BASE = 8;
  localparam longint unsigned CLK_HZ = 1000000;
  localparam int INH = int'((CLK_HZ * 16) / 10000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0, alc_en = 1'b0, wr_en = 1'b0, smp_valid = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic [5:0] wr_code = 6'h00, alc_code = 6'h00;
  logic [SMP_W-1:0] smp = '0;
  logic [5:0] gain, seed;
  logic busy;

  int tests = 0;
  int fails = 0;

  int m_cur, m_tgt, m_seed, m_hb, m_cnt, m_inh;
  bit m_prev, m_pwr_prev, m_alc_prev;

  always #4 clk = ~clk;

  zc_gain_ctrl #(.SMP_W(SMP_W), .TMO_BASE(TMO_BASE), .CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .alc_en_i(alc_en),
    .tmo_sel_i(tmo_sel), .wr_en_i(wr_en), .wr_code_i(wr_code),
    .alc_code_i(alc_code), .smp_valid_i(smp_valid), .smp_i(smp),
    .gain_o(gain), .alc_seed_o(seed), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_gain();
    return alc_en ? int'(alc_code) : m_cur;
  endfunction

  function automatic int m_busy();
    return ((m_inh != 0) || (m_hb != 0) || (!alc_en && m_tgt != m_cur)) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_cur = 'h18; m_tgt = 'h18; m_seed = 'h18; m_hb = 0; m_cnt = 0; m_inh = 0;
    m_prev = 0; m_pwr_prev = 0; m_alc_prev = 0;
  endtask

  task automatic model_step();
    bit rise, afall, arise, zc, tmo, evt, acc, rst_cnt;
    int per, n_cur, n_tgt, n_hb;
    rise  = pwr_en && !m_pwr_prev;
    arise = alc_en && !m_alc_prev;
    afall = !alc_en && m_alc_prev;
    per   = TMO_BASE << tmo_sel;
    zc    = smp_valid && (smp[SMP_W-1] != m_prev);
    tmo   = smp_valid && (m_cnt >= per - 1);
    evt   = zc || tmo;
    acc   = wr_en && pwr_en && !rise && (m_inh == 0) && !alc_en;
    rst_cnt = rise || acc || afall || (evt && !alc_en && (m_hb != 0 || m_tgt != m_cur));
    n_cur = m_cur; n_tgt = m_tgt; n_hb = m_hb;
    if (rise) begin
      n_cur = 'h18; n_tgt = 'h18; n_hb = 0;
    end else begin
      if (acc) n_tgt = int'(wr_code);
      if (alc_en) begin n_cur = int'(alc_code); n_hb = 0; end
      else if (afall) n_hb = 2;
      else if (m_hb != 0) begin
        if (evt) begin
          if (m_hb == 1) begin n_cur = m_tgt; n_hb = 0; end
          else n_hb = 1;
        end
      end else if (evt && m_tgt != m_cur) n_cur = m_tgt;
    end
    if (arise) m_seed = m_cur;
    if (rst_cnt) m_cnt = 0;
    else if (smp_valid) m_cnt = tmo ? 0 : m_cnt + 1;
    if (smp_valid) m_prev = smp[SMP_W-1];
    if (!pwr_en) m_inh = 0;
    else if (rise) m_inh = INH;
    else if (m_inh != 0) m_inh--;
    m_pwr_prev = pwr_en; m_alc_prev = alc_en;
    m_cur = n_cur; m_tgt = n_tgt; m_hb = n_hb;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #2;
    chk("R2 gain vs model", int'(gain), m_gain());
    chk("R10 busy vs model", int'(busy), m_busy());
    chk("R7 seed vs model", int'(seed), m_seed);
  endtask

  task automatic sample(input bit v, input bit neg);
    smp_valid = v;
    smp = neg ? 16'hFF00 : 16'h0100;
    tick();
    smp_valid = 1'b0;
  endtask

  task automatic write(input logic [5:0] c);
    wr_en = 1'b1; wr_code = c;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    model_reset();
    @(posedge clk); #2;
    rst_n = 1'b1;
    chk("R1 reset gain", int'(gain), 'h18);
    chk("R1 reset seed", int'(seed), 'h18);
    chk("R1 reset busy", int'(busy), 0);

    // R4: writes while powered off
    write(6'h30);
    sample(1'b1, 1'b1);
    sample(1'b1, 1'b0);
    chk("R4 gain after off write", int'(gain), 'h18);
    chk("R4 busy after off write", int'(busy), 0);

    // power on, wait out the window
    pwr_en = 1'b1;
    tick();
    chk("R6 busy in window", int'(busy), 1);
    for (int i = 0; i < INH + 4; i++) tick();
    chk("R6 busy after window", int'(busy), 0);

    // R2: zero crossing
    tmo_sel = 2'd3;
    sample(1'b1, 1'b0);
    write(6'h20);
    chk("R10 busy pending", int'(busy), 1);
    for (int i = 0; i < 3; i++) sample(1'b1, 1'b0);
    chk("R2 held before crossing", int'(gain), 'h18);
    sample(1'b1, 1'b1);
    chk("R2 applied at crossing", int'(gain), 'h20);
    chk("R10 busy cleared", int'(busy), 0);

    // R3 + R11: timeout, period 8, invalid opposite-sign samples between
    tmo_sel = 2'd0;
    sample(1'b1, 1'b0);
    write(6'h05);
    for (int i = 0; i < 7; i++) begin
      sample(1'b1, 1'b0);
      sample(1'b0, 1'b1);
    end
    chk("R11 invalid samples ignored", int'(gain), 'h20);
    sample(1'b1, 1'b0);
    chk("R3 applied at 8th strobe", int'(gain), 'h05);

    // R3: period 32, minimum code
    tmo_sel = 2'd2;
    write(6'h00);
    for (int i = 0; i < 31; i++) sample(1'b1, 1'b0);
    chk("R3 held at 31 strobes", int'(gain), 'h05);
    sample(1'b1, 1'b0);
    chk("R3 applied at 32nd strobe", int'(gain), 'h00);

    // R7/R8/R9: ALC hand-over and hand-back
    alc_code = 6'h2A; alc_en = 1'b1;
    write(6'h11);
    chk("R7 gain follows ALC", int'(gain), 'h2A);
    chk("R7 seed captured", int'(seed), 'h00);
    alc_code = 6'h2B;
    tick();
    alc_en = 1'b0;
    tick();
    chk("R9 holds last ALC code", int'(gain), 'h2B);
    chk("R10 busy in hand-back", int'(busy), 1);
    sample(1'b1, 1'b1);
    chk("R9 held after first event", int'(gain), 'h2B);
    sample(1'b1, 1'b0);
    chk("R9 R8 manual code restored", int'(gain), 'h00);
    chk("R9 hand-back done", int'(busy), 0);

    // R5/R6: power cycle, write inside window dropped
    pwr_en = 1'b0;
    tick();
    pwr_en = 1'b1;
    tick();
    chk("R5 gain at power-up", int'(gain), 'h18);
    for (int i = 0; i < 50; i++) tick();
    write(6'h3F);
    for (int i = 0; i < INH; i++) tick();
    chk("R6 in-window write dropped", int'(busy), 0);
    chk("R6 gain unchanged", int'(gain), 'h18);
    write(6'h3F);
    chk("R10 busy after accepted write", int'(busy), 1);
    sample(1'b1, 1'b1);
    chk("R2 max code applied", int'(gain), 'h3F);

    // random mix against the reference model
    for (int i = 0; i < 6000; i++) begin
      smp_valid = ($urandom % 2) == 1;
      smp       = SMP_W'($urandom);
      wr_en     = ($urandom % 12) == 0;
      wr_code   = 6'($urandom);
      alc_code  = 6'($urandom);
      if ($urandom % 300 == 0) tmo_sel = 2'($urandom);
      if ($urandom % 150 == 0) alc_en = ~alc_en;
      if (pwr_en) begin
        if ($urandom % 900 == 0) pwr_en = 1'b0;
      end else if ($urandom % 20 == 0) pwr_en = 1'b1;
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule